// File: doc/BRIEF.md
# Rotation-Mode CORDIC Sine/Cosine Oscillator

This block is the numerically controlled oscillator of an all-digital phase-locked loop. On every clock a 16-bit binary-angle phase register advances by the sum of an unsigned centre-frequency word and a signed correction word from the loop filter. The sum wraps. The phase value is then turned into a sine and cosine pair by a pipelined CORDIC working in rotation mode. No lookup table is used, so the output resolution is changed by changing the number of pipeline stages and nothing else.

Before the iterations start, the phase is folded into the range the CORDIC can converge over, which is ±π/2. Angles in the second and third quadrants are shifted by π, and both results are negated at the output. The start vector is pre-scaled by the inverse of the CORDIC gain, so the final vector comes out with unit amplitude in Q1.14.

Top module: `nco_cordic_osc`

## Requirements
- R1: While `rst` is high at a clock edge, `sin_out` and `cos_out` become 0 and `out_valid` becomes low at that edge.
- R2: After `rst` falls, `out_valid` rises at exactly the LAT-th rising edge (LAT = STAGES + 2, 16 by default). It then stays high until the next reset.
- R3: The phase register starts at 0 after reset. At each edge it takes phase + `freq_word` + `tune_word` modulo 2^16, with `tune_word` read as two's complement.
- R4: When valid, `cos_out` is within ±12 LSB of round(16384·cos(2π·p/65536)), where p is the phase value that generated the sample.
- R5: When valid, `sin_out` is within ±12 LSB of round(16384·sin(2π·p/65536)) for the same p.
- R6: Phases whose top two bits are 01 or 10 (the second and third quadrants) give results with the same accuracy as R4 and R5. This is achieved by a shift of π followed by negation of both outputs.
- R7: A negative `tune_word` lowers the phase step. When `tune_word` = −`freq_word`, the phase stops moving and both outputs hold constant.
- R8: The sample that appears after edge k was generated by the phase register value present just before edge k−LAT+1. That is, the latency from the phase register to the outputs is fixed at LAT edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 16 | Unsigned centre-frequency phase step |
| tune_word | input | 16 | Signed correction added to the step each sample |
| sin_out | output | 16 | Signed sine sample, Q1.14 |
| cos_out | output | 16 | Signed cosine sample, Q1.14 |
| out_valid | output | 1 | High once the pipeline holds a real sample |

## Verification
A wrong phase register value corrupts every later sample: the sine and cosine drift off the expected curve exactly LAT edges after the fault and never recover. A wrong quadrant fold or a missed negation shows up as a sign or mirror error across half of the phase circle, so it is visible within one sweep of 65536 phases. Errors in the stage constants or shifts show up as amplitude or angle errors of more than a few LSB at particular angles. An exhaustive unit-step sweep therefore exposes them at the first phase they affect.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // atan(2^-i) expressed in binary-angle units where 2^16 is a full turn
  function automatic int atan_bam16(input int idx);
    case (idx)
      0:  return 8192;
      1:  return 4836;
      2:  return 2555;
      3:  return 1297;
      4:  return 651;
      5:  return 326;
      6:  return 163;
      7:  return 81;
      8:  return 41;
      9:  return 20;
      10: return 10;
      11: return 5;
      12: return 3;
      13: return 1;
      14: return 1;
      default: return 0;
    endcase
  endfunction

  // same angle rescaled to a phase word of pw bits
  function automatic int atan_scaled(input int idx, input int pw);
    int base;
    base = atan_bam16(idx);
    if (pw >= 16) return base <<< (pw - 16);
    return base >>> (16 - pw);
  endfunction

  // inverse CORDIC gain (about 0.60725) with frac fractional bits
  function automatic int start_gain(input int frac);
    if (frac >= 16) return 39797 <<< (frac - 16);
    return (39797 + (1 <<< (15 - frac))) >>> (16 - frac);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] freq_i,
  input  logic [PW-1:0] tune_i,
  output logic [PW-1:0] phase_o
);
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + freq_i + tune_i;
  end

  assign phase_o = phase_q;

  // R3
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> PW'(phase_q - $past(phase_q)) == PW'($past(freq_i) + $past(tune_i)));

endmodule

// File: rtl/nco_quadrant_fold.sv
module nco_quadrant_fold #(
  parameter int PW   = 16,
  parameter int ZW   = 17,
  parameter int DW   = 18,
  parameter int FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        phase_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [ZW-1:0] z_o,
  output logic                 neg_o
);
  import nco_pkg::*;

  localparam int HALF_PI = 2 ** (PW - 2);
  localparam logic signed [DW-1:0] X_START = DW'(start_gain(FRAC));

  logic [1:0]    quad;
  logic          outer;
  logic [PW-1:0] angle_bits;

  assign quad       = phase_i[PW-1:PW-2];
  assign outer      = quad[1] ^ quad[0];
  assign angle_bits = {phase_i[PW-1] ^ outer, phase_i[PW-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      x_o   <= '0;
      y_o   <= '0;
      z_o   <= '0;
      neg_o <= 1'b0;
    end else begin
      x_o   <= X_START;
      y_o   <= '0;
      z_o   <= ZW'($signed(angle_bits));
      neg_o <= outer;
    end
  end

  // R6
  fold_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(z_o) >= -HALF_PI) && (int'(z_o) < HALF_PI));

endmodule

// File: rtl/nco_cordic_stage.sv
module nco_cordic_stage #(
  parameter int DW  = 18,
  parameter int ZW  = 17,
  parameter int PW  = 16,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  input  logic                 neg_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [ZW-1:0] z_o,
  output logic                 neg_o
);
  import nco_pkg::*;

  localparam int STEP_I = atan_scaled(IDX, PW);
  localparam logic signed [ZW-1:0] STEP = ZW'(STEP_I);

  logic                 turn_pos;
  logic signed [DW-1:0] x_sh, y_sh;
  int                   z_mag;

  assign turn_pos = ~z_i[ZW-1];
  assign x_sh     = x_i >>> IDX;
  assign y_sh     = y_i >>> IDX;
  assign z_mag    = (z_o < 0) ? -int'(z_o) : int'(z_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_o   <= '0;
      y_o   <= '0;
      z_o   <= '0;
      neg_o <= 1'b0;
    end else begin
      x_o   <= turn_pos ? x_i - y_sh : x_i + y_sh;
      y_o   <= turn_pos ? y_i + x_sh : y_i - x_sh;
      z_o   <= turn_pos ? z_i - STEP : z_i + STEP;
      neg_o <= neg_i;
    end
  end

  // R4
  residual_bound_chk: assert property (@(posedge clk) disable iff (rst)
    z_mag <= STEP_I + 16);

endmodule

// File: rtl/nco_cordic_osc.sv
module nco_cordic_osc #(
  parameter int PHASE_W = 16,
  parameter int OUT_W   = 16,
  parameter int STAGES  = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PHASE_W-1:0]      freq_word,
  input  logic [PHASE_W-1:0]      tune_word,
  output logic signed [OUT_W-1:0] sin_out,
  output logic signed [OUT_W-1:0] cos_out,
  output logic                    out_valid
);
  localparam int FRAC = OUT_W - 2;
  localparam int DW   = OUT_W + 2;
  localparam int ZW   = PHASE_W + 1;
  localparam int LAT  = STAGES + 2;
  localparam int AMP  = 2 ** FRAC + 16;

  logic [PHASE_W-1:0]   phase;
  logic signed [DW-1:0] xs [0:STAGES];
  logic signed [DW-1:0] ys [0:STAGES];
  logic signed [ZW-1:0] zs [0:STAGES];
  logic                 negs [0:STAGES];
  logic [LAT-1:0]       vld_q;

  nco_phase_acc #(.PW(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .freq_i(freq_word), .tune_i(tune_word), .phase_o(phase)
  );

  nco_quadrant_fold #(.PW(PHASE_W), .ZW(ZW), .DW(DW), .FRAC(FRAC)) u_fold (
    .clk(clk), .rst(rst), .phase_i(phase),
    .x_o(xs[0]), .y_o(ys[0]), .z_o(zs[0]), .neg_o(negs[0])
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    nco_cordic_stage #(.DW(DW), .ZW(ZW), .PW(PHASE_W), .IDX(g)) u_stage (
      .clk(clk), .rst(rst),
      .x_i(xs[g]), .y_i(ys[g]), .z_i(zs[g]), .neg_i(negs[g]),
      .x_o(xs[g+1]), .y_o(ys[g+1]), .z_o(zs[g+1]), .neg_o(negs[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_out <= '0;
      cos_out <= '0;
      vld_q   <= '0;
    end else begin
      cos_out <= OUT_W'(negs[STAGES] ? -xs[STAGES] : xs[STAGES]);
      sin_out <= OUT_W'(negs[STAGES] ? -ys[STAGES] : ys[STAGES]);
      vld_q   <= {vld_q[LAT-2:0], 1'b1};
    end
  end

  assign out_valid = vld_q[LAT-1];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sin_out == 0) && (cos_out == 0) && !out_valid);

  // R2
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  // R4
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(cos_out) <= AMP) && (int'(cos_out) >= -AMP)
               && (int'(sin_out) <= AMP) && (int'(sin_out) >= -AMP));

endmodule

// File: tb/test_nco_cordic_osc.sv
`timescale 1ns/1ps
module test_nco_cordic_osc;
  localparam int STAGES = 14;
  localparam int LAT    = STAGES + 2;
  localparam int TOL    = 12;
  localparam real TWO_PI = 6.283185307179586;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [15:0]        freq = '0;
  logic [15:0]        tune = '0;
  logic signed [15:0] sin_o, cos_o;
  logic               vld;

  int total = 0;
  int bad   = 0;

  logic [15:0] macc;
  logic [15:0] hist [0:LAT-1];
  logic        vhist [0:LAT-1];

  always #4 clk = ~clk;

  nco_cordic_osc #(.PHASE_W(16), .OUT_W(16), .STAGES(STAGES)) i_nco_cordic_osc (
    .clk(clk), .rst(rst), .freq_word(freq), .tune_word(tune),
    .sin_out(sin_o), .cos_out(cos_o), .out_valid(vld)
  );

  // independent reference: phase register and a LAT-deep delay line (R3, R8)
  always @(posedge clk) begin
    if (rst) macc <= '0;
    else     macc <= macc + freq + tune;
    hist[0]  <= macc;
    vhist[0] <= !rst;
    for (int k = 1; k < LAT; k++) begin
      hist[k]  <= rst ? '0 : hist[k-1];
      vhist[k] <= rst ? 1'b0 : vhist[k-1];
    end
  end

  task automatic check(input string req, input int act, input int exp, input int tol);
    total++;
    if (act > exp + tol || act < exp - tol) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare outputs with trig values of the delayed reference phase
  task automatic run(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (vhist[LAT-1]) begin
        logic [15:0] p;
        real ang;
        int ec, es;
        string q;
        p   = hist[LAT-1];
        ang = TWO_PI * real'(p) / 65536.0;
        ec  = $rtoi($floor(16384.0 * $cos(ang) + 0.5));
        es  = $rtoi($floor(16384.0 * $sin(ang) + 0.5));
        q   = (p[15] ^ p[14]) ? " R6" : "";
        check({"R4 cos", q, " ", tag}, int'(cos_o), ec, TOL);
        check({"R5 sin", q, " ", tag}, int'(sin_o), es, TOL);
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    freq = 16'd1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sin", int'(sin_o), 0, 0);
    check("R1 cos", int'(cos_o), 0, 0);
    check("R1 valid", int'(vld), 0, 0);
    rst = 1'b0;
    // R2 valid rises on the LAT-th edge after release
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      check("R2 valid timing", int'(vld), (k == LAT) ? 1 : 0, 0);
    end
    // exhaustive unit-step sweep: every phase, all four quadrants
    run(65536 + LAT, "R8 sweep");
    check("R2 valid held", int'(vld), 1, 0);
    // R3 signed tuning and wrap of the phase sum
    freq = 16'h1234; tune = 16'hFF00;
    run(600, "R3 mixed step");
    freq = 16'hFFF0; tune = 16'h0020;
    run(400, "R3 wrap");
    // R7 tuning cancels the centre word: phase and outputs freeze
    freq = 16'd700; tune = 16'(-700);
    run(LAT + 4, "R7 settle");
    begin
      int s0, c0;
      s0 = int'(sin_o); c0 = int'(cos_o);
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        check("R7 sin frozen", int'(sin_o), s0, 0);
        check("R7 cos frozen", int'(cos_o), c0, 0);
      end
    end
    // R8 one-cycle half-turn jump: output flips after exactly LAT edges
    freq = 16'd0; tune = 16'd0;
    run(LAT + 2, "R8 hold");
    freq = 16'h8000;
    run(1, "R8 jump");
    freq = 16'd0;
    run(LAT + 6, "R8 after jump");
    // R1 reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1 sin again", int'(sin_o), 0, 0);
    check("R1 valid again", int'(vld), 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule